// File: doc/BRIEF.md
# Short-Lived Result Holding File

This block is a small associative store for result values that become dead early. A result is dead early when a younger instruction has already remapped its destination architectural register before the result is written back. Holding such values here means the datapath writes neither the reorder buffer nor the architectural register file for them. Each entry is keyed by the reorder-buffer slot of the producing instruction. An entry also records the destination register, the data, and two branch tags: one for the branch just before the remapping instruction, and one for the branch just before the producer.

Two status bits are kept for every reorder-buffer slot. One says that the slot currently has a live entry here. The other says that the producer has not yet committed. The bits decide four things: whether a committing instruction may skip its architectural copy, whether the remapping instruction's commit removes the entry, where a squashed entry's value is sent, and whether a new write is accepted.

Removal is event driven. A commit of the remapping instruction drops the entry. A mispredicted producer branch drops it silently. A mispredicted remapper branch sends the value back out. A precise exception sends every live value to the architectural file. Values leave one per cycle through a single drain port, and writes are refused while the drain is busy.

Top module: `shortlived_rf`

## Requirements
- R1: After reset no entry is live: `busy` and `drain_valid` are 0, and `commit_skip` is 0 for any slot.
- R2: An accepted write stores its slot, register, data and both tags in the lowest-numbered free entry. Entries are drained in index order, so drain order shows where each write landed.
- R3: `wr_accept` is 1 only when all of these hold: `wr_valid` is 1, `busy` is 0, neither `squash_valid` nor `exc_valid` is 1 in that cycle, a free entry exists, and no live entry already holds the same slot. A write that is refused changes no state.
- R4: `commit_skip` is 1, in the same cycle, when `commit_valid` is 1 and the committing slot has a live entry.
- R5: A commit of a slot clears that slot's not-yet-committed bit. A slot's bit is set again only by a new accepted write.
- R6: A flush request for a slot removes its entry only if the slot has a live entry and its producer has already committed. Otherwise the request has no effect.
- R7: A squash whose tag equals an entry's producer tag (`wr_tag_prod`) removes that entry without draining it.
- R8: A squash whose tag equals an entry's remapper tag (`wr_tag_remap`) queues that entry for drain. On drain, `drain_to_arf` is 1 (architectural file) if the producer has committed and 0 (reorder buffer) if it has not.
- R9: When both tags of one entry equal the squash tag, the entry is removed and not drained.
- R10: `exc_valid` queues every live entry for drain with `drain_to_arf` forced to 1.
- R11: The drain port emits one queued entry per cycle, lowest index first, and frees that entry on the same edge. `busy` is 1 while any entry is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write-back request for a short-lived value |
| wr_rob | input | ROB_W | Producer reorder-buffer slot |
| wr_areg | input | AREG_W | Destination architectural register |
| wr_data | input | DATA_W | Result value |
| wr_tag_remap | input | TAG_W | Branch tag before the remapping instruction |
| wr_tag_prod | input | TAG_W | Branch tag before the producer |
| wr_accept | output | 1 | Write taken into the file this cycle |
| busy | output | 1 | Drain in progress; writes refused |
| commit_valid | input | 1 | A producer commits |
| commit_rob | input | ROB_W | Committing slot |
| commit_skip | output | 1 | Committing value is held here; skip architectural copy |
| flush_valid | input | 1 | Remapping instruction commits with a flush slot |
| flush_slot | input | ROB_W | Slot whose entry may be dropped |
| squash_valid | input | 1 | Branch misprediction |
| squash_tag | input | TAG_W | Tag of the mispredicted branch |
| exc_valid | input | 1 | Precise exception: drain all to architectural file |
| drain_valid | output | 1 | Drain port carries an entry |
| drain_to_arf | output | 1 | 1 = architectural file, 0 = reorder buffer |
| drain_rob | output | ROB_W | Drained entry's slot |
| drain_areg | output | AREG_W | Drained entry's register |
| drain_data | output | DATA_W | Drained entry's value |

## Verification
The bench builds the block with four entries and a sixteen-slot reorder buffer. With only four entries, a full file and refused writes occur within a few cycles. With sixteen slots, random traffic often reuses slots and collides on duplicates. Tags are drawn from a narrow range, so one squash hits several entries at once, and an entry carrying the same value in both tags is easy to produce. That brings tag priority and multi-entry drains within reach.

// File: rtl/shortlived_pkg.sv
package shortlived_pkg;

    typedef enum logic {
        DEST_ROB = 1'b0,
        DEST_ARF = 1'b1
    } dest_e;

endpackage

// File: rtl/slrf_first_set.sv
module slrf_first_set #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/slrf_match_array.sv
module slrf_match_array #(
    parameter int ENTRIES = 32,
    parameter int ROB_W   = 6,
    parameter int TAG_W   = 4
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][ROB_W-1:0] rob,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tag_remap,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tag_prod,
    input  logic [ROB_W-1:0]              key_a,
    input  logic [ROB_W-1:0]              key_b,
    input  logic [TAG_W-1:0]              key_tag,
    output logic [ENTRIES-1:0]            hit_a,
    output logic [ENTRIES-1:0]            hit_b,
    output logic [ENTRIES-1:0]            hit_remap,
    output logic [ENTRIES-1:0]            hit_prod
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign hit_a[g]     = vld[g] && (rob[g] == key_a);
        assign hit_b[g]     = vld[g] && (rob[g] == key_b);
        assign hit_remap[g] = vld[g] && (tag_remap[g] == key_tag);
        assign hit_prod[g]  = vld[g] && (tag_prod[g] == key_tag);
    end
endmodule

// File: rtl/shortlived_rf.sv
module shortlived_rf
    import shortlived_pkg::*;
#(
    parameter int ENTRIES   = 32,
    parameter int ROB_DEPTH = 64,
    parameter int DATA_W    = 32,
    parameter int AREG_W    = 5,
    parameter int TAG_W     = 4,
    localparam int ROB_W    = $clog2(ROB_DEPTH),
    localparam int EIDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ROB_W-1:0]  wr_rob,
    input  logic [AREG_W-1:0] wr_areg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag_remap,
    input  logic [TAG_W-1:0]  wr_tag_prod,
    output logic              wr_accept,
    output logic              busy,
    input  logic              commit_valid,
    input  logic [ROB_W-1:0]  commit_rob,
    output logic              commit_skip,
    input  logic              flush_valid,
    input  logic [ROB_W-1:0]  flush_slot,
    input  logic              squash_valid,
    input  logic [TAG_W-1:0]  squash_tag,
    input  logic              exc_valid,
    output logic              drain_valid,
    output logic              drain_to_arf,
    output logic [ROB_W-1:0]  drain_rob,
    output logic [AREG_W-1:0] drain_areg,
    output logic [DATA_W-1:0] drain_data
);
    typedef struct packed {
        logic              vld;
        logic              pend;
        logic              pend_arf;
        logic [ROB_W-1:0]  rob;
        logic [AREG_W-1:0] areg;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag_remap;
        logic [TAG_W-1:0]  tag_prod;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [ROB_DEPTH-1:0] alloc;
        logic [ROB_DEPTH-1:0] uncommitted;
    } state_t;

    state_t state_q, state_d;

    logic [ENTRIES-1:0]            vld_vec, pend_vec;
    logic [ENTRIES-1:0][ROB_W-1:0] rob_vec;
    logic [ENTRIES-1:0][TAG_W-1:0] t_remap_vec, t_prod_vec;
    logic [ENTRIES-1:0]            hit_wr, hit_flush, hit_remap, hit_prod;
    logic                          free_found, drn_found;
    logic [EIDX_W-1:0]             free_idx, drn_idx;
    logic                          flush_ok;
    dest_e                         drn_dest;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i]     = state_q.ent[i].vld;
            pend_vec[i]    = state_q.ent[i].pend;
            rob_vec[i]     = state_q.ent[i].rob;
            t_remap_vec[i] = state_q.ent[i].tag_remap;
            t_prod_vec[i]  = state_q.ent[i].tag_prod;
        end
    end

    slrf_match_array #(
        .ENTRIES(ENTRIES), .ROB_W(ROB_W), .TAG_W(TAG_W)
    ) u_match (
        .vld(vld_vec), .rob(rob_vec), .tag_remap(t_remap_vec), .tag_prod(t_prod_vec),
        .key_a(wr_rob), .key_b(flush_slot), .key_tag(squash_tag),
        .hit_a(hit_wr), .hit_b(hit_flush), .hit_remap(hit_remap), .hit_prod(hit_prod)
    );

    slrf_first_set #(.N(ENTRIES)) u_free (
        .req(~vld_vec), .found(free_found), .idx(free_idx)
    );

    slrf_first_set #(.N(ENTRIES)) u_drain (
        .req(pend_vec), .found(drn_found), .idx(drn_idx)
    );

    // Output decode
    assign busy        = |pend_vec;
    assign wr_accept   = wr_valid && !busy && !squash_valid && !exc_valid
                         && free_found && !(|hit_wr);
    assign commit_skip = commit_valid && state_q.alloc[commit_rob];
    assign flush_ok    = flush_valid && state_q.alloc[flush_slot]
                         && !state_q.uncommitted[flush_slot];

    always_comb begin
        drn_dest = (state_q.ent[drn_idx].pend_arf
                    || !state_q.uncommitted[state_q.ent[drn_idx].rob]) ? DEST_ARF : DEST_ROB;
    end

    assign drain_valid  = drn_found;
    assign drain_to_arf = (drn_dest == DEST_ARF);
    assign drain_rob    = state_q.ent[drn_idx].rob;
    assign drain_areg   = state_q.ent[drn_idx].areg;
    assign drain_data   = state_q.ent[drn_idx].data;

    // Next-state logic
    always_comb begin
        state_d = state_q;

        if (drn_found) begin
            state_d.ent[drn_idx].vld      = 1'b0;
            state_d.ent[drn_idx].pend     = 1'b0;
            state_d.ent[drn_idx].pend_arf = 1'b0;
            state_d.alloc[state_q.ent[drn_idx].rob] = 1'b0;
        end

        if (commit_valid) state_d.uncommitted[commit_rob] = 1'b0;

        if (flush_ok) begin
            state_d.alloc[flush_slot] = 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (hit_flush[i]) begin
                    state_d.ent[i].vld      = 1'b0;
                    state_d.ent[i].pend     = 1'b0;
                    state_d.ent[i].pend_arf = 1'b0;
                end
            end
        end

        if (squash_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (hit_prod[i]) begin
                    state_d.ent[i].vld      = 1'b0;
                    state_d.ent[i].pend     = 1'b0;
                    state_d.ent[i].pend_arf = 1'b0;
                    state_d.alloc[state_q.ent[i].rob]       = 1'b0;
                    state_d.uncommitted[state_q.ent[i].rob] = 1'b0;
                end else if (hit_remap[i] && state_d.ent[i].vld) begin
                    state_d.ent[i].pend = 1'b1;
                end
            end
        end

        if (exc_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (state_d.ent[i].vld) begin
                    state_d.ent[i].pend     = 1'b1;
                    state_d.ent[i].pend_arf = 1'b1;
                end
            end
        end

        if (wr_accept) begin
            state_d.ent[free_idx].vld       = 1'b1;
            state_d.ent[free_idx].pend      = 1'b0;
            state_d.ent[free_idx].pend_arf  = 1'b0;
            state_d.ent[free_idx].rob       = wr_rob;
            state_d.ent[free_idx].areg      = wr_areg;
            state_d.ent[free_idx].data      = wr_data;
            state_d.ent[free_idx].tag_remap = wr_tag_remap;
            state_d.ent[free_idx].tag_prod  = wr_tag_prod;
            state_d.alloc[wr_rob]           = 1'b1;
            state_d.uncommitted[wr_rob]     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Assertions
    assert_busy_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_accept);

    assert_write_marks_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> state_q.alloc[$past(wr_rob)]);

    assert_slot_count_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_vec) == $countones(state_q.alloc));

    assert_drain_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |=> !state_q.alloc[$past(drain_rob)]);

    assert_flush_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && state_q.alloc[flush_slot] && !state_q.uncommitted[flush_slot])
        |=> !state_q.alloc[$past(flush_slot)]);

    assert_queued_is_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec & ~vld_vec) == '0);

    assert_skip_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_skip |-> commit_valid);
endmodule

// File: tb/shortlived_rf_bench.sv
module shortlived_rf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int E   = 4;
    localparam int RD  = 16;
    localparam int RW  = 4;
    localparam int DW  = 32;
    localparam int AW  = 5;
    localparam int TW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, commit_valid = 0, flush_valid = 0, squash_valid = 0, exc_valid = 0;
    logic [RW-1:0] wr_rob = 0, commit_rob = 0, flush_slot = 0;
    logic [AW-1:0] wr_areg = 0;
    logic [DW-1:0] wr_data = 0;
    logic [TW-1:0] wr_tag_remap = 0, wr_tag_prod = 0, squash_tag = 0;
    logic wr_accept, busy, commit_skip, drain_valid, drain_to_arf;
    logic [RW-1:0] drain_rob;
    logic [AW-1:0] drain_areg;
    logic [DW-1:0] drain_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shortlived_rf #(.ENTRIES(E), .ROB_DEPTH(RD), .DATA_W(DW), .AREG_W(AW), .TAG_W(TW)) u_shortlived_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_rob(wr_rob), .wr_areg(wr_areg), .wr_data(wr_data),
        .wr_tag_remap(wr_tag_remap), .wr_tag_prod(wr_tag_prod), .wr_accept(wr_accept), .busy(busy),
        .commit_valid(commit_valid), .commit_rob(commit_rob), .commit_skip(commit_skip),
        .flush_valid(flush_valid), .flush_slot(flush_slot),
        .squash_valid(squash_valid), .squash_tag(squash_tag), .exc_valid(exc_valid),
        .drain_valid(drain_valid), .drain_to_arf(drain_to_arf), .drain_rob(drain_rob),
        .drain_areg(drain_areg), .drain_data(drain_data)
    );

    // Reference model state
    bit m_vld[E], m_pend[E], m_parf[E];
    int m_rob[E], m_areg[E];
    logic [DW-1:0] m_data[E];
    int m_tr[E], m_tp[E];
    bit m_alloc[RD], m_unc[RD];

    // Expected outputs
    bit e_acc, e_busy, e_skip, e_dv, e_arf;
    int e_fi, e_di;

    function automatic void model_reset();
        for (int i = 0; i < E; i++) begin
            m_vld[i] = 0; m_pend[i] = 0; m_parf[i] = 0;
        end
        for (int s = 0; s < RD; s++) begin
            m_alloc[s] = 0; m_unc[s] = 0;
        end
    endfunction

    function automatic void model_eval();
        bit dup = 0;
        e_busy = 0; e_fi = -1; e_di = -1;
        for (int i = E - 1; i >= 0; i--) begin
            if (m_pend[i]) begin e_busy = 1; e_di = i; end
            if (!m_vld[i]) e_fi = i;
            if (m_vld[i] && m_rob[i] == int'(wr_rob)) dup = 1;
        end
        e_acc  = wr_valid && !e_busy && !squash_valid && !exc_valid && (e_fi >= 0) && !dup;
        e_skip = commit_valid && m_alloc[commit_rob];
        e_dv   = (e_di >= 0);
        e_arf  = e_dv ? (m_parf[e_di] || !m_unc[m_rob[e_di]]) : 1'b0;
    endfunction

    function automatic void model_next();
        bit flush_ok = flush_valid && m_alloc[flush_slot] && !m_unc[flush_slot];
        bit old_vld[E];
        for (int i = 0; i < E; i++) old_vld[i] = m_vld[i];
        if (e_dv) begin
            m_vld[e_di] = 0; m_pend[e_di] = 0; m_parf[e_di] = 0;
            m_alloc[m_rob[e_di]] = 0;
        end
        if (commit_valid) m_unc[commit_rob] = 0;
        if (flush_ok) begin
            m_alloc[flush_slot] = 0;
            for (int i = 0; i < E; i++)
                if (old_vld[i] && m_rob[i] == int'(flush_slot)) begin
                    m_vld[i] = 0; m_pend[i] = 0; m_parf[i] = 0;
                end
        end
        if (squash_valid) begin
            for (int i = 0; i < E; i++) begin
                if (old_vld[i] && m_tp[i] == int'(squash_tag)) begin
                    m_vld[i] = 0; m_pend[i] = 0; m_parf[i] = 0;
                    m_alloc[m_rob[i]] = 0; m_unc[m_rob[i]] = 0;
                end else if (old_vld[i] && m_tr[i] == int'(squash_tag) && m_vld[i]) begin
                    m_pend[i] = 1;
                end
            end
        end
        if (exc_valid) begin
            for (int i = 0; i < E; i++)
                if (m_vld[i]) begin m_pend[i] = 1; m_parf[i] = 1; end
        end
        if (e_acc) begin
            m_vld[e_fi] = 1; m_pend[e_fi] = 0; m_parf[e_fi] = 0;
            m_rob[e_fi] = int'(wr_rob); m_areg[e_fi] = int'(wr_areg); m_data[e_fi] = wr_data;
            m_tr[e_fi] = int'(wr_tag_remap); m_tp[e_fi] = int'(wr_tag_prod);
            m_alloc[wr_rob] = 1; m_unc[wr_rob] = 1;
        end
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_valid = 0; commit_valid = 0; flush_valid = 0; squash_valid = 0; exc_valid = 0;
    endtask

    // One cycle: inputs already driven after a falling edge
    task automatic tick();
        #1;
        model_eval();
        chk("R3", "wr_accept", 64'(wr_accept), 64'(e_acc));
        chk("R11", "busy", 64'(busy), 64'(e_busy));
        chk("R4", "commit_skip", 64'(commit_skip), 64'(e_skip));
        chk("R11", "drain_valid", 64'(drain_valid), 64'(e_dv));
        if (e_dv) begin
            chk("R8", "drain_to_arf", 64'(drain_to_arf), 64'(e_arf));
            chk("R2", "drain_rob", 64'(drain_rob), 64'(m_rob[e_di]));
            chk("R2", "drain_areg", 64'(drain_areg), 64'(m_areg[e_di]));
            chk("R2", "drain_data", 64'(drain_data), 64'(m_data[e_di]));
        end
        @(posedge clk);
        model_next();
        @(negedge clk);
        idle();
    endtask

    task automatic do_wr(input int rob, input int areg, input logic [DW-1:0] data, input int tr, input int tp);
        wr_valid = 1; wr_rob = RW'(rob); wr_areg = AW'(areg); wr_data = data;
        wr_tag_remap = TW'(tr); wr_tag_prod = TW'(tp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        commit_valid = 1; commit_rob = 0;
        #1;
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "drain_valid", 64'(drain_valid), 64'd0);
        chk("R1", "commit_skip", 64'(commit_skip), 64'd0);
        tick();

        // R2 and R3: fill, duplicate, full
        do_wr(1, 3, 32'hA1, 9, 10); tick();
        do_wr(2, 4, 32'hA2, 9, 11); tick();
        do_wr(1, 5, 32'hBAD, 9, 12); tick();   // R3 duplicate slot refused
        do_wr(3, 6, 32'hA3, 12, 13); tick();
        do_wr(4, 7, 32'hA4, 14, 14); tick();
        do_wr(5, 8, 32'hA5, 9, 10); tick();    // R3 file full
        // R4: skip on live slot, not on empty one
        commit_valid = 1; commit_rob = 1; tick();
        commit_valid = 1; commit_rob = 9; tick();
        // R6: flush before producer commit has no effect, then after (R5)
        flush_valid = 1; flush_slot = 2; tick();
        commit_valid = 1; commit_rob = 2; tick();
        commit_valid = 1; commit_rob = 2; tick();  // R4 slot 2 still live
        flush_valid = 1; flush_slot = 2; tick();
        commit_valid = 1; commit_rob = 2; tick();  // R6 now removed
        // R7: producer-tag squash removes slot 1 silently
        squash_valid = 1; squash_tag = 10; tick();
        // R9: entry slot 4 has both tags 14
        squash_valid = 1; squash_tag = 14; tick();
        // R8: remapper-tag squash drains slot 3 to reorder buffer
        do_wr(6, 9, 32'hB6, 12, 1); tick();
        squash_valid = 1; squash_tag = 12; tick();
        do_wr(7, 1, 32'hC7, 2, 3); tick();      // R11 refused while busy
        tick(); tick();
        // R10: exception drains everything to the architectural file
        do_wr(8, 2, 32'hD8, 2, 3); tick();
        do_wr(9, 3, 32'hD9, 2, 3); tick();
        exc_valid = 1; tick();
        repeat (4) tick();

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom % 10);
            if (op < 5) begin
                do_wr(int'($urandom % RD), int'($urandom % 32), $urandom, int'($urandom % 4), int'($urandom % 4));
            end else if (op == 5) begin
                commit_valid = 1; commit_rob = RW'($urandom % RD);
            end else if (op == 6) begin
                flush_valid = 1; flush_slot = RW'($urandom % RD);
            end else if (op == 7) begin
                squash_valid = ($urandom % 3 == 0); squash_tag = TW'($urandom % 4);
            end else if (op == 8) begin
                commit_valid = 1; commit_rob = RW'($urandom % RD);
                flush_valid = 1; flush_slot = RW'($urandom % RD);
            end else begin
                exc_valid = ($urandom % 8 == 0);
            end
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule